// File: doc/BRIEF.md
# Serial-to-Parallel Byte Collector with Grant-Gated Write Address

The collector takes a one-bit serial stream and packs it into bytes. While the enable input is high, every clock edge takes in one bit. After the eighth such bit, the assembled byte appears on the parallel output, and a data-valid strobe marks it for exactly one cycle. The byte then stays on the output until the next byte is complete.

Next to the byte assembler sits a write-address counter for a downstream memory. The counter moves to the next location only when the memory side acknowledges with the grant input. Without grant, the address holds.

Lowering enable freezes the whole block: the partly assembled byte, the bit position and the address all keep their values. A synchronous, active-high reset returns every register to zero, and it takes priority over enable and grant.

Top module: `serial_byte_collector`

## Requirements
- R1: On a clock edge with rst high, par_out, byte_valid and wr_addr all become zero and the bit position returns to the first bit. This holds whatever en and grant are.
- R2: Bits are taken in MSB-first order: the first bit after reset or after a completed byte lands in par_out bit 7, and the eighth lands in bit 0.
- R3: At the edge that takes the eighth enabled bit, par_out is loaded with the new byte and byte_valid is raised. byte_valid is high for exactly one cycle per byte.
- R4: Between two completed bytes, par_out keeps its value.
- R5: At an edge with en low, no bit is taken in and the bit position does not move. byte_valid is low after that edge.
- R6: wr_addr increases by one at each edge where en and grant are both high, and holds at every other edge.
- R7: Grant has no effect while en is low: the address holds.
- R8: wr_addr is 16 bits wide and goes from 16'hFFFF to 16'h0000 on the next granted step.
- R9: A grant in the same cycle that completes a byte advances wr_addr exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables bit capture, counting and address stepping |
| ser_in | input | 1 | Serial data bit |
| grant | input | 1 | Memory-side acknowledge; steps the write address |
| par_out | output | 8 | Last completed byte, MSB-first |
| byte_valid | output | 1 | One-cycle strobe for a newly completed byte |
| wr_addr | output | 16 | Memory write address |

## Verification
If the bit counter drifts, byte_valid appears at the wrong edge. The bench compares every cycle against a model, so this shows within one byte period, at most eight enabled cycles. A wrong shift direction or a slip in the shift register shows on par_out at the very next completed byte. A mis-gated address counter differs on wr_addr one cycle after the grant that should or should not have counted. The long granted run also exposes a wrong wrap at 16'hFFFF.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   function automatic int unsigned pos_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sbc_bit_counter.sv
module sbc_bit_counter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic last_bit,
   output logic valid_q
);
   localparam int unsigned CW = sbc_pkg::pos_width(DATA_W);
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [CW-1:0] pos_q;

   assign last_bit = en && (pos_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= last_bit;
         if (en) begin
            if (pos_q == LAST) pos_q <= '0;
            else               pos_q <= pos_q + 1'b1;
         end
      end
   end

   assert_pos_range_R3: assert property (@(posedge clk) disable iff (rst)
      pos_q <= LAST);
   assert_pos_frozen_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en)) |-> $stable(pos_q));
endmodule

// File: rtl/sbc_shifter.sv
module sbc_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              bit_in,
   input  logic              load,
   output logic [DATA_W-1:0] byte_q
);
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_q[DATA_W-2:0], bit_in};
      end else begin : g_lsb
         assign sh_next = {bit_in, sh_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         byte_q <= '0;
      end else if (en) begin
         sh_q <= sh_next;
         if (load) byte_q <= sh_next;
      end
   end

   assert_shift_frozen_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en)) |-> ($stable(sh_q) && $stable(byte_q)));
endmodule

// File: rtl/sbc_addr_counter.sv
module sbc_addr_counter #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (rst)       addr_q <= '0;
      else if (step) addr_q <= addr_q + 1'b1;
   end

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(step)) |-> $stable(addr_q));
   assert_addr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(step)) |-> (addr_q == ADDR_W'($past(addr_q) + 1)));
endmodule

// File: rtl/serial_byte_collector.sv
module serial_byte_collector #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              ser_in,
   input  logic              grant,
   output logic [DATA_W-1:0] par_out,
   output logic              byte_valid,
   output logic [ADDR_W-1:0] wr_addr
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("serial_byte_collector: DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("serial_byte_collector: ADDR_W must be at least 1");
      end
   endgenerate

   logic last_bit;
   logic addr_step;

   assign addr_step = en && grant;

   sbc_bit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .en(en),
      .last_bit(last_bit), .valid_q(byte_valid)
   );

   sbc_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst(rst), .en(en), .bit_in(ser_in),
      .load(last_bit), .byte_q(par_out)
   );

   sbc_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst(rst), .step(addr_step), .addr_q(wr_addr)
   );

   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      byte_valid |=> !byte_valid);
   assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(par_out)) |-> byte_valid);
   assert_pause_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en)) |-> !byte_valid);
   assert_grant_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en)) |-> $stable(wr_addr));
endmodule

// File: tb/tb_serial_byte_collector.sv
module tb_serial_byte_collector;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic ser_in = 1'b0;
   logic grant = 1'b0;
   logic [7:0]  par_out;
   logic        byte_valid;
   logic [15:0] wr_addr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0]  m_sh = '0;
   logic [7:0]  m_byte = '0;
   logic        m_valid = 1'b0;
   logic [15:0] m_addr = '0;
   int          m_pos = 0;

   always #10 clk = ~clk;

   serial_byte_collector dut (
      .clk(clk), .rst(rst), .en(en), .ser_in(ser_in), .grant(grant),
      .par_out(par_out), .byte_valid(byte_valid), .wr_addr(wr_addr)
   );

   task automatic model_edge();
      if (rst) begin
         m_sh = '0; m_byte = '0; m_valid = 1'b0; m_addr = '0; m_pos = 0;
      end else begin
         m_valid = 1'b0;
         if (en) begin
            m_sh = {m_sh[6:0], ser_in};
            if (m_pos == 7) begin
               m_byte = m_sh; m_valid = 1'b1; m_pos = 0;
            end else begin
               m_pos = m_pos + 1;
            end
            if (grant) m_addr = m_addr + 16'd1;
         end
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, 32'(par_out), 32'(m_byte), "par_out");
      check(tag, 32'(byte_valid), 32'(m_valid), "byte_valid");
      check(tag, 32'(wr_addr), 32'(m_addr), "wr_addr");
   endtask

   // apply inputs at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic cyc(input logic r, input logic e, input logic s, input logic g, input string tag);
      rst = r; en = e; ser_in = s; grant = g;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic g, input string tag);
      for (int i = 7; i >= 0; i--) cyc(1'b0, 1'b1, b[i], g, tag);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd5150);
      @(negedge clk);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      check("R1", 32'(par_out), 32'h0, "reset par_out");
      check("R1", 32'(wr_addr), 32'h0, "reset wr_addr");

      // R2 and R3: a directed byte, MSB first
      send_byte(8'hA5, 1'b0, "R2");
      check("R2", 32'(par_out), 32'hA5, "msb-first byte");
      check("R3", 32'(byte_valid), 32'h1, "valid after eighth bit");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R3");
      check("R3", 32'(byte_valid), 32'h0, "valid drops after one cycle");

      // R4 and R5: pause in the middle of a byte with grant toggling (R7)
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R4");
      check("R4", 32'(par_out), 32'hA5, "output held mid-byte");
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'(i), 1'b1, "R7");
      check("R7", 32'(wr_addr), 32'h0, "grant ignored while disabled");
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R5");
      check("R5", 32'(par_out), 32'hE0, "pause kept bit position");

      // R9: grant on the completing bit only
      for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R9");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, "R9");
      check("R9", 32'(wr_addr), 32'h1, "single step on completing grant");
      check("R9", 32'(par_out), 32'hFE, "byte with grant");

      // R1: reset wins over enable and grant
      cyc(1'b0, 1'b1, 1'b1, 1'b1, "R6");
      cyc(1'b1, 1'b1, 1'b1, 1'b1, "R1");
      check("R1", 32'(wr_addr), 32'h0, "reset priority on address");
      check("R1", 32'(par_out), 32'h0, "reset priority on output");
      send_byte(8'h3C, 1'b0, "R1");
      check("R1", 32'(par_out), 32'h3C, "bit position restarted");

      // R6 random mix
      for (int i = 0; i < 3000; i++)
         cyc(1'b0, 1'(($urandom % 10) < 8), 1'($urandom), 1'(($urandom % 10) < 3), "R6");

      // R8: wrap of the address
      cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      for (int i = 0; i < 65535; i++) cyc(1'b0, 1'b1, 1'($urandom), 1'b1, "R6");
      check("R8", 32'(wr_addr), 32'hFFFF, "address at all ones");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, "R8");
      check("R8", 32'(wr_addr), 32'h0, "address wrapped");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, "R8");
      check("R8", 32'(wr_addr), 32'h1, "address after wrap");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule